// File: doc/BRIEF.md
# External Memory Strobe Sequencer

This block drives the control strobes of one external memory access on one chip select. The strobes are chip select, address valid, output enable and write enable. A single start pulse begins an access, and a tick counter then runs from zero in functional-clock ticks. Each strobe is driven low (active) inside a window whose opening and closing ticks software programs. The closing tick of chip select and of address valid can differ between reads and writes, and so can the total length of the access. A separately programmed sample tick raises a one-cycle capture pulse so read data can be registered at that point. A done pulse marks the last tick.

All timing fields, the direction flag, the sync-mode flag and the clock divider are sampled when the access starts, so the controlling logic may change them freely while an access runs. In synchronous mode the block also produces a bus clock phase indicator. This is the functional clock divided by 1 to 4, restarted at tick zero of every access, and a downstream clock gate combines it with the functional clock. Control inputs and status outputs are plain pins. There is no data stream through this block, so it has no valid/ready interface.

Top module: `bus_strobe_seq`

## Requirements
- R1: While reset is held, and whenever no access is running, cs_n_o, adv_n_o, oe_n_o and we_n_o are 1 and capture_o, done_o and bus_clk_o are 0. A start pulse during reset is ignored.
- R2: A start pulse seen at a rising edge while idle begins an access whose tick is 0 in the following cycle. Chip select is low exactly in the ticks t with cs_on_i <= t < cs_off. Address valid is low exactly in the ticks t with adv_on_i <= t < adv_off. Each off value is the read or the write field, chosen by write_i (1 = write).
- R3: During a read (write_i = 0), oe_n_o is low exactly in the ticks oe_on_i <= t < oe_off_i and we_n_o stays 1. During a write, we_n_o is low exactly in the ticks we_on_i <= t < we_off_i and oe_n_o stays 1.
- R4: A strobe whose off value is less than or equal to its on value stays 1 for the whole access.
- R5: capture_o is 1 for exactly the tick equal to sample_at_i, and only on reads. It does not fire if sample_at_i exceeds the read length.
- R6: done_o is 1 for exactly the tick equal to the length of the current direction (rd_len_i or wr_len_i). An access therefore spans length+1 ticks, and the next cycle is idle.
- R7: A start pulse is ignored while an access runs, including its done cycle. With start held high, a new access begins after one idle cycle.
- R8: All timing inputs, write_i, sync_i and div_i are sampled at the accepted start. Changing them during an access has no effect on that access.
- R9: With sync_i = 1, the divide ratio is d = div_i + 1. bus_clk_o is 1 in tick t exactly when (t mod d) < ceil(d/2), which holds it 1 on every tick for d = 1. With sync_i = 0, bus_clk_o stays 0.
- R10: A programmed on time or sample time of zero places the event at tick 0, the first cycle of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start an access (accepted only while idle) |
| write_i | input | 1 | 1 = write access, 0 = read access |
| sync_i | input | 1 | 1 = synchronous mode, bus clock produced |
| div_i | input | 2 | Bus clock divide ratio minus one |
| cs_on_i | input | 4 | Chip select assert tick |
| cs_rd_off_i | input | 5 | Chip select deassert tick on reads |
| cs_wr_off_i | input | 5 | Chip select deassert tick on writes |
| adv_on_i | input | 4 | Address valid assert tick |
| adv_rd_off_i | input | 5 | Address valid deassert tick on reads |
| adv_wr_off_i | input | 5 | Address valid deassert tick on writes |
| oe_on_i | input | 4 | Output enable assert tick |
| oe_off_i | input | 5 | Output enable deassert tick |
| we_on_i | input | 4 | Write enable assert tick |
| we_off_i | input | 5 | Write enable deassert tick |
| rd_len_i | input | 5 | Final tick of a read access |
| wr_len_i | input | 5 | Final tick of a write access |
| sample_at_i | input | 5 | Read data capture tick |
| cs_n_o | output | 1 | Chip select, active low |
| adv_n_o | output | 1 | Address valid, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| capture_o | output | 1 | One-tick read data capture pulse |
| bus_clk_o | output | 1 | Divided bus clock phase (high half) |
| done_o | output | 1 | One-tick pulse on the final tick |

## Verification
The bench targets the window edges. It programs windows that open at tick 0 or at the largest on value, and windows that close beyond the access length. A comparison off by one would stretch or shorten a strobe by one tick. Empty windows, where off is at or below on, and a sample tick past the end check that a design cannot leave a strobe stuck low or fire a stray capture. A held start exposes a design that restarts mid-access or skips the idle cycle. Inputs changed mid-access expose a design that reads live pins instead of the sampled copy. The bus clock is compared at every divide ratio, where a phase counter that is not reset at start would shift the pattern.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int ON_W   = 4;
  localparam int OFF_W  = 5;
  localparam int TICK_W = 5;
  localparam int DIV_W  = 2;
  localparam int NSTRB  = 4;

  // strobe slots in the window array
  localparam int S_CS  = 0;
  localparam int S_ADV = 1;
  localparam int S_OE  = 2;
  localparam int S_WE  = 3;

  typedef struct packed {
    logic [ON_W-1:0]  on;
    logic [OFF_W-1:0] off;
  } win_t;

  typedef struct packed {
    win_t [NSTRB-1:0]  win;
    logic [TICK_W-1:0] len;
    logic [TICK_W-1:0] smp;
    logic              wr;
    logic              sync;
    logic [DIV_W-1:0]  div;
  } acc_cfg_t;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  acc_cfg_t          cfg_i,
  output acc_cfg_t          cfg_q_o,
  output logic              active_o,
  output logic              load_o,
  output logic [TICK_W-1:0] tick_o,
  output logic              done_o
);
  acc_cfg_t          cfg_q;
  logic              active;
  logic [TICK_W-1:0] tick;
  logic              load;
  logic              last;

  assign load = !active && start_i;
  assign last = active && (tick == cfg_q.len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      tick   <= '0;
      cfg_q  <= '0;
    end else if (load) begin
      active <= 1'b1;
      tick   <= '0;
      cfg_q  <= cfg_i;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      tick   <= tick + 1'b1;
    end
  end

  assign cfg_q_o  = cfg_q;
  assign active_o = active;
  assign load_o   = load;
  assign tick_o   = tick;
  assign done_o   = last;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !active_o);
  assert_tick_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !done_o) |=> active_o && (tick_o == $past(tick_o) + 1'b1));
  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && $past(active_o)) |-> $stable(cfg_q_o));
  assert_start_tick0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> active_o && (tick_o == '0));
endmodule

// File: rtl/bseq_window.sv
module bseq_window #(
  parameter int ON_W   = 4,
  parameter int OFF_W  = 5,
  parameter int TICK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              allow_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic [ON_W-1:0]   on_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic              strobe_n_o
);
  localparam int CW = (TICK_W > OFF_W) ? TICK_W : OFF_W;

  logic [CW-1:0] t_ext, on_ext, off_ext;
  logic          opened, not_closed;

  assign t_ext      = CW'(tick_i);
  assign on_ext     = CW'(on_i);
  assign off_ext    = CW'(off_i);
  assign opened     = t_ext >= on_ext;
  assign not_closed = t_ext < off_ext;
  assign strobe_n_o = !(active_i && allow_i && opened && not_closed);

  assert_empty_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (off_ext <= on_ext) |-> strobe_n_o);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |-> strobe_n_o);
endmodule

// File: rtl/bseq_clkdiv.sv
module bseq_clkdiv #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             active_i,
  input  logic             sync_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bus_clk_o
);
  logic [DIV_W-1:0] phase;
  logic [DIV_W:0]   half;

  // high portion of a d-tick period is ceil(d/2), with d = div+1
  assign half = ({1'b0, div_i} + 2'd2) >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n)          phase <= '0;
    else if (load_i)     phase <= '0;
    else if (active_i) begin
      if (phase == div_i) phase <= '0;
      else                phase <= phase + 1'b1;
    end
  end

  assign bus_clk_o = active_i && sync_i && ({1'b0, phase} < half);

  assert_phase_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (phase <= div_i));
  assert_async_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |-> !bus_clk_o);
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import bseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       write_i,
  input  logic       sync_i,
  input  logic [1:0] div_i,
  input  logic [3:0] cs_on_i,
  input  logic [4:0] cs_rd_off_i,
  input  logic [4:0] cs_wr_off_i,
  input  logic [3:0] adv_on_i,
  input  logic [4:0] adv_rd_off_i,
  input  logic [4:0] adv_wr_off_i,
  input  logic [3:0] oe_on_i,
  input  logic [4:0] oe_off_i,
  input  logic [3:0] we_on_i,
  input  logic [4:0] we_off_i,
  input  logic [4:0] rd_len_i,
  input  logic [4:0] wr_len_i,
  input  logic [4:0] sample_at_i,
  output logic       cs_n_o,
  output logic       adv_n_o,
  output logic       oe_n_o,
  output logic       we_n_o,
  output logic       capture_o,
  output logic       bus_clk_o,
  output logic       done_o
);
  acc_cfg_t          cfg_in, cfg_q;
  logic              active, load, done;
  logic [TICK_W-1:0] tick;
  logic [NSTRB-1:0]  allow, strobe_n;

  // direction picks the off ticks and the length before they are latched
  always_comb begin
    cfg_in              = '0;
    cfg_in.win[S_CS]    = '{on: cs_on_i,  off: write_i ? cs_wr_off_i  : cs_rd_off_i};
    cfg_in.win[S_ADV]   = '{on: adv_on_i, off: write_i ? adv_wr_off_i : adv_rd_off_i};
    cfg_in.win[S_OE]    = '{on: oe_on_i,  off: oe_off_i};
    cfg_in.win[S_WE]    = '{on: we_on_i,  off: we_off_i};
    cfg_in.len          = write_i ? wr_len_i : rd_len_i;
    cfg_in.smp          = sample_at_i;
    cfg_in.wr           = write_i;
    cfg_in.sync         = sync_i;
    cfg_in.div          = div_i;
  end

  bseq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cfg_i    (cfg_in),
    .cfg_q_o  (cfg_q),
    .active_o (active),
    .load_o   (load),
    .tick_o   (tick),
    .done_o   (done)
  );

  always_comb begin
    allow        = '1;
    allow[S_OE]  = !cfg_q.wr;
    allow[S_WE]  = cfg_q.wr;
  end

  for (genvar g = 0; g < NSTRB; g++) begin : g_win
    bseq_window #(.ON_W(ON_W), .OFF_W(OFF_W), .TICK_W(TICK_W)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (active),
      .allow_i    (allow[g]),
      .tick_i     (tick),
      .on_i       (cfg_q.win[g].on),
      .off_i      (cfg_q.win[g].off),
      .strobe_n_o (strobe_n[g])
    );
  end

  bseq_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .active_i  (active),
    .sync_i    (cfg_q.sync),
    .div_i     (cfg_q.div),
    .bus_clk_o (bus_clk_o)
  );

  assign cs_n_o    = strobe_n[S_CS];
  assign adv_n_o   = strobe_n[S_ADV];
  assign oe_n_o    = strobe_n[S_OE];
  assign we_n_o    = strobe_n[S_WE];
  assign capture_o = active && !cfg_q.wr && (tick == cfg_q.smp);
  assign done_o    = done;

  assert_oe_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_o |-> !cfg_q.wr);
  assert_we_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> cfg_q.wr);
  assert_capture_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |-> active && !cfg_q.wr);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (cs_n_o && adv_n_o && oe_n_o && we_n_o && !capture_o && !done_o));
  always_comb begin
    if (rst_n === 1'b0)
      assert_reset_quiet_R1: assert (cs_n_o && we_n_o && !done_o);
  end
endmodule

// File: tb/sim_bus_strobe_seq.sv
module sim_bus_strobe_seq;
  typedef struct packed {
    logic       wr;
    logic       sync;
    logic [1:0] div;
    logic [3:0] cs_on;
    logic [4:0] cs_rd, cs_wr;
    logic [3:0] av_on;
    logic [4:0] av_rd, av_wr;
    logic [3:0] oe_on;
    logic [4:0] oe_off;
    logic [3:0] we_on;
    logic [4:0] we_off;
    logic [4:0] rd_len, wr_len, smp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd0, 4'd0,5'd10,5'd12, 4'd0,5'd3,5'd5,  4'd2,5'd9,  4'd1,5'd8,  5'd11,5'd13,5'd7},
    '{1'b1,1'b0,2'd0, 4'd0,5'd10,5'd12, 4'd0,5'd3,5'd5,  4'd2,5'd9,  4'd1,5'd8,  5'd11,5'd13,5'd7},
    '{1'b0,1'b1,2'd2, 4'd3,5'd12,5'd12, 4'd4,5'd4,5'd4,  4'd6,5'd3,  4'd0,5'd20, 5'd15,5'd15,5'd20},
    '{1'b1,1'b1,2'd3, 4'd15,5'd0,5'd31, 4'd0,5'd0,5'd1,  4'd0,5'd31, 4'd0,5'd31, 5'd0,5'd31,5'd5},
    '{1'b0,1'b1,2'd0, 4'd0,5'd1,5'd1,   4'd0,5'd0,5'd0,  4'd0,5'd1,  4'd0,5'd1,  5'd0,5'd0,5'd0},
    '{1'b0,1'b1,2'd1, 4'd15,5'd31,5'd31,4'd15,5'd31,5'd0,4'd5,5'd31, 4'd0,5'd31, 5'd31,5'd31,5'd31}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic wr, sync; logic [1:0] div;
  logic [3:0] cs_on, av_on, oe_on, we_on;
  logic [4:0] cs_rd, cs_wr, av_rd, av_wr, oe_off, we_off, rd_len, wr_len, smp;
  logic cs_n, adv_n, oe_n, we_n, cap, bclk, done;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  bus_strobe_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .write_i(wr), .sync_i(sync), .div_i(div),
    .cs_on_i(cs_on), .cs_rd_off_i(cs_rd), .cs_wr_off_i(cs_wr),
    .adv_on_i(av_on), .adv_rd_off_i(av_rd), .adv_wr_off_i(av_wr),
    .oe_on_i(oe_on), .oe_off_i(oe_off), .we_on_i(we_on), .we_off_i(we_off),
    .rd_len_i(rd_len), .wr_len_i(wr_len), .sample_at_i(smp),
    .cs_n_o(cs_n), .adv_n_o(adv_n), .oe_n_o(oe_n), .we_n_o(we_n),
    .capture_o(cap), .bus_clk_o(bclk), .done_o(done)
  );

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(vec_t v);
    wr = v.wr; sync = v.sync; div = v.div;
    cs_on = v.cs_on; cs_rd = v.cs_rd; cs_wr = v.cs_wr;
    av_on = v.av_on; av_rd = v.av_rd; av_wr = v.av_wr;
    oe_on = v.oe_on; oe_off = v.oe_off; we_on = v.we_on; we_off = v.we_off;
    rd_len = v.rd_len; wr_len = v.wr_len; smp = v.smp;
  endtask

  function automatic logic inwin(int t, int on, int off);
    return (t >= on) && (t < off);
  endfunction

  task automatic check_idle(string req);
    check(req, "idle cs_n", cs_n, 1'b1);
    check(req, "idle adv_n", adv_n, 1'b1);
    check(req, "idle oe_n", oe_n, 1'b1);
    check(req, "idle we_n", we_n, 1'b1);
    check(req, "idle capture", cap, 1'b0);
    check(req, "idle done", done, 1'b0);
    check(req, "idle bus_clk", bclk, 1'b0);
  endtask

  // one access; when disturb is set other inputs are applied after tick 0 (R8)
  task automatic run(vec_t v, bit disturb, vec_t alt);
    int len, csoff, avoff, d;
    len   = v.wr ? int'(v.wr_len) : int'(v.rd_len);
    csoff = v.wr ? int'(v.cs_wr) : int'(v.cs_rd);
    avoff = v.wr ? int'(v.av_wr) : int'(v.av_rd);
    d     = int'(v.div) + 1;
    @(negedge clk); drive(v); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t <= len; t++) begin
      string rq;
      rq = disturb ? "R8" : "";
      check(disturb ? "R8" : (v.cs_on == 0 ? "R10" : "R2"), "cs_n", cs_n, !inwin(t, v.cs_on, csoff));
      check(disturb ? "R8" : "R2", "adv_n", adv_n, !inwin(t, v.av_on, avoff));
      check(disturb ? "R8" : "R3", "oe_n", oe_n, !(!v.wr && inwin(t, v.oe_on, v.oe_off)));
      check(disturb ? "R8" : "R3", "we_n", we_n, !(v.wr && inwin(t, v.we_on, v.we_off)));
      check(disturb ? "R8" : "R5", "capture", cap, !v.wr && (t == int'(v.smp)));
      check(disturb ? "R8" : "R6", "done", done, t == len);
      check(disturb ? "R8" : "R9", "bus_clk", bclk, v.sync && ((t % d) < ((d + 1) / 2)));
      if (disturb && t == 0) drive(alt);
      @(negedge clk);
    end
    check_idle("R6");
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_fail++;
    $display("FAIL R6 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    vec_t r7;
    drive(VECS[0]);
    // R1: reset holds everything quiet, start during reset ignored
    start = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");
    start = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1");

    // table walk: R2 R3 R4 R5 R6 R9 R10
    for (int i = 0; i < NV; i++) run(VECS[i], 1'b0, VECS[i]);

    // R8: change everything (including direction) during the access
    begin
      vec_t alt;
      alt = VECS[2];
      alt.wr = 1'b1;
      run(VECS[0], 1'b1, alt);
    end

    // R7: start held high; period is len+1 ticks plus one idle cycle
    r7 = VECS[0];
    r7.cs_on = 4'd1; r7.cs_rd = 5'd3; r7.rd_len = 5'd4; r7.smp = 5'd2;
    @(negedge clk); drive(r7); start = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 12; c++) begin
      int t;
      t = c % 6;
      if (t <= 4) begin
        check("R7", "held cs_n", cs_n, !inwin(t, 1, 3));
        check("R7", "held done", done, t == 4);
      end else begin
        check("R7", "gap cs_n", cs_n, 1'b1);
        check("R7", "gap done", done, 1'b0);
      end
      @(negedge clk);
    end
    start = 1'b0;
    repeat (8) @(negedge clk);
    check_idle("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule